// File: doc/BRIEF.md
# Piecewise-Linear Sigmoid Interpolator

This block is a pipelined fixed-point unit that evaluates a smooth activation curve, normally a sigmoid, from a small table of samples. Each signed 16-bit input is clamped to the span the table covers. The upper bits of the clamped value pick a segment of the curve and the lower bits give the position inside that segment. The unit reads the two samples at the ends of the segment and blends them linearly into a 16-bit result.

The sample table has a single read port. The two endpoints of a segment are therefore fetched in back-to-back cycles, and the input stream is throttled to one accepted value every second cycle. Software or a loader writes the table through a separate write port before streaming begins. The table can also be rewritten between streams to change the curve.

Top module: `pwl_sigmoid`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 0 in the cycle right after an input is accepted (`in_valid` and `in_ready` both 1 at a rising edge), and 1 in every other cycle.
- R3: Each accepted input produces exactly one `out_valid` pulse of one cycle, 3 clock edges after the edge that accepted it, and no other `out_valid` pulse occurs.
- R4: The input is signed Q4.11. For in-range inputs (-16384 <= x <= 16383 as an integer), u = x + 16384, the segment index i = u[14:9] (0..63) and the fraction f = u[8:0]. The result is y = T[i] + floor(((T[i+1] - T[i]) * f + 256) / 512), kept to 16 bits. T values are unsigned 16-bit numbers.
- R5: An input below -16384 (below -8.0) gives exactly T[0].
- R6: An input of 16384 or above (+8.0 or more) gives exactly T[64].
- R7: An in-range input with f = 0 (a segment boundary) gives exactly T[i].
- R8: Rounding is to nearest with ties toward plus infinity. With f = 256, the result is T[i] + floor((d*256 + 256) / 512), where d = T[i+1] - T[i].
- R9: A write with `tbl_we` = 1 at a rising edge stores `tbl_wdata` at entry `tbl_addr` (0..64). Later results use the new value.
- R10: With `in_valid` held high, inputs are accepted on every second edge, and results appear on every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_x | input | 16 | Signed Q4.11 input sample |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| out_y | output | 16 | Interpolated result |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table entry written (0..64) |
| tbl_wdata | input | 16 | Table entry value |

## Verification
A result is due 3 rising edges after the edge that accepted its input. `in_ready` is due low only in the cycle after an accept. The bench samples every output at the falling edge. It pushes each accept, with its expected value, into a four-slot shift line that advances once per cycle. The slot that reaches the end must match `out_valid` in that same cycle. Saturation, boundary and tie inputs are tagged by class, so each check names the requirement it covers.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
   // Rounding applied when the scaled slope product is reduced.
   typedef enum logic [0:0] {
      PWL_RND_NEAREST = 1'b0,
      PWL_RND_TRUNC   = 1'b1
   } pwl_round_e;
endpackage

// File: rtl/pwl_addr_gen.sv
module pwl_addr_gen #(
   parameter int IN_W      = 16,
   parameter int IN_FRAC   = 11,
   parameter int RANGE_EXP = 3,
   parameter int SEG_BITS  = 6,
   localparam int U_W      = RANGE_EXP + 1 + IN_FRAC,
   localparam int FRAC_W   = U_W - SEG_BITS,
   localparam int AW       = SEG_BITS + 1
) (
   input  logic signed [IN_W-1:0] x,
   output logic [AW-1:0]          addr0,
   output logic [AW-1:0]          addr1,
   output logic [FRAC_W-1:0]      frac
);
   localparam int OFS = 1 << (RANGE_EXP + IN_FRAC);
   localparam logic [AW-1:0] TOP_ADDR = AW'(1 << SEG_BITS);

   logic signed [IN_W:0] x_ext;
   logic signed [IN_W:0] u_full;
   logic                 below;
   logic                 above;

   assign x_ext  = x;
   assign u_full = x_ext + (IN_W+1)'(OFS);
   assign below  = u_full[IN_W];
   assign above  = !u_full[IN_W] && (|u_full[IN_W-1:U_W]);

   always_comb begin
      if (below) begin
         addr0 = '0;
         addr1 = '0;
         frac  = '0;
      end else if (above) begin
         addr0 = TOP_ADDR;
         addr1 = TOP_ADDR;
         frac  = '0;
      end else begin
         addr0 = {1'b0, u_full[U_W-1:FRAC_W]};
         addr1 = {1'b0, u_full[U_W-1:FRAC_W]} + AW'(1);
         frac  = u_full[FRAC_W-1:0];
      end
   end
endmodule

// File: rtl/pwl_table.sv
module pwl_table #(
   parameter int DW    = 16,
   parameter int AW    = 7,
   parameter int DEPTH = 65
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) begin
         mem[waddr] <= wdata;
      end
      if (int'(raddr) < DEPTH) begin
         rdata <= mem[raddr];
      end else begin
         rdata <= '0;
      end
   end
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp
   import pwl_pkg::*;
#(
   parameter int         DW         = 16,
   parameter int         FRAC_W     = 9,
   parameter pwl_round_e ROUND_MODE = PWL_RND_NEAREST,
   localparam int        PW         = DW + FRAC_W + 2
) (
   input  logic [DW-1:0]     y0,
   input  logic [DW-1:0]     y1,
   input  logic [FRAC_W-1:0] frac,
   output logic [DW-1:0]     y
);
   logic signed [DW:0]   diff;
   logic signed [PW-1:0] d_ext;
   logic signed [PW-1:0] f_ext;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] rounded;
   logic signed [PW-1:0] step;
   logic signed [PW-1:0] sum;

   assign diff  = $signed({1'b0, y1}) - $signed({1'b0, y0});
   assign d_ext = PW'(diff);
   assign f_ext = $signed(PW'({1'b0, frac}));
   assign prod  = d_ext * f_ext;

   if (ROUND_MODE == PWL_RND_NEAREST) begin : g_nearest
      assign rounded = prod + PW'(1 << (FRAC_W - 1));
   end else begin : g_trunc
      assign rounded = prod;
   end

   assign step = rounded >>> FRAC_W;
   assign sum  = step + $signed(PW'({1'b0, y0}));
   assign y    = sum[DW-1:0];
endmodule

// File: rtl/pwl_sigmoid.sv
module pwl_sigmoid
   import pwl_pkg::*;
#(
   parameter int         IN_W       = 16,
   parameter int         IN_FRAC    = 11,
   parameter int         RANGE_EXP  = 3,
   parameter int         SEG_BITS   = 6,
   parameter int         OUT_W      = 16,
   parameter pwl_round_e ROUND_MODE = PWL_RND_NEAREST,
   localparam int        U_W        = RANGE_EXP + 1 + IN_FRAC,
   localparam int        FRAC_W     = U_W - SEG_BITS,
   localparam int        AW         = SEG_BITS + 1,
   localparam int        DEPTH      = (1 << SEG_BITS) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic signed [IN_W-1:0] in_x,
   output logic                  out_valid,
   output logic [OUT_W-1:0]      out_y,
   input  logic                  tbl_we,
   input  logic [AW-1:0]         tbl_addr,
   input  logic [OUT_W-1:0]      tbl_wdata
);
   if (U_W >= IN_W) begin : g_bad_range
      $error("pwl_sigmoid: table span does not fit inside the input width");
   end
   if (SEG_BITS < 1 || SEG_BITS > 10) begin : g_bad_seg
      $error("pwl_sigmoid: SEG_BITS out of supported range");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("pwl_sigmoid: no fraction bits left");
   end

   logic              accept;
   logic              phase_a0;
   logic              phase_a1;
   logic [AW-1:0]     g_a0;
   logic [AW-1:0]     g_a1;
   logic [FRAC_W-1:0] g_frac;
   logic [AW-1:0]     s1_a0;
   logic [AW-1:0]     s1_a1;
   logic [FRAC_W-1:0] s1_frac;
   logic [AW-1:0]     rd_addr;
   logic [OUT_W-1:0]  rd_data;
   logic [OUT_W-1:0]  s2_y0;
   logic [FRAC_W-1:0] s2_frac;
   logic              s2_valid;
   logic [OUT_W-1:0]  interp_y;

   assign in_ready = !phase_a0;
   assign accept   = in_valid && in_ready;

   pwl_addr_gen #(
      .IN_W(IN_W), .IN_FRAC(IN_FRAC), .RANGE_EXP(RANGE_EXP), .SEG_BITS(SEG_BITS)
   ) i_addr_gen (
      .x(in_x), .addr0(g_a0), .addr1(g_a1), .frac(g_frac)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_a0 <= 1'b0;
         phase_a1 <= 1'b0;
         s1_a0    <= '0;
         s1_a1    <= '0;
         s1_frac  <= '0;
      end else begin
         phase_a0 <= accept;
         phase_a1 <= phase_a0;
         if (accept) begin
            s1_a0   <= g_a0;
            s1_a1   <= g_a1;
            s1_frac <= g_frac;
         end
      end
   end

   // Lower endpoint is fetched in the cycle after accept, upper one next.
   assign rd_addr = phase_a0 ? s1_a0 : s1_a1;

   pwl_table #(
      .DW(OUT_W), .AW(AW), .DEPTH(DEPTH)
   ) i_table (
      .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
      .raddr(rd_addr), .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_y0    <= '0;
         s2_frac  <= '0;
         s2_valid <= 1'b0;
      end else begin
         s2_valid <= phase_a1;
         if (phase_a1) begin
            s2_y0   <= rd_data;
            s2_frac <= s1_frac;
         end
      end
   end

   pwl_interp #(
      .DW(OUT_W), .FRAC_W(FRAC_W), .ROUND_MODE(ROUND_MODE)
   ) i_interp (
      .y0(s2_y0), .y1(rd_data), .frac(s2_frac), .y(interp_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            out_y <= interp_y;
         end
      end
   end
endmodule

// File: rtl/pwl_sigmoid_chk.sv
module pwl_sigmoid_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid
);
   logic [3:0] acc_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hist <= '0;
      end else begin
         acc_hist <= {acc_hist[2:0], in_valid && in_ready};
      end
   end

   p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == acc_hist[3]);

   p_out_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in_ready && !out_valid));
endmodule

bind pwl_sigmoid pwl_sigmoid_chk i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/test_pwl_sigmoid.sv
`timescale 1ns/1ps
module test_pwl_sigmoid;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_ready;
   logic signed [15:0] in_x = '0;
   logic               out_valid;
   logic [15:0]        out_y;
   logic               tbl_we = 1'b0;
   logic [6:0]         tbl_addr = '0;
   logic [15:0]        tbl_wdata = '0;

   always #2.5 clk = ~clk;

   pwl_sigmoid i_pwl_sigmoid (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_x(in_x), .out_valid(out_valid), .out_y(out_y),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [15:0]        tbl [0:64];
   logic signed [15:0] stim [0:899];
   int                 n_stim = 0;

   logic        pv [1:4];
   logic [15:0] py [1:4];
   string       pt [1:4];
   logic        last_acc = 1'b0;
   int          cyc = 0;
   int          first_out = -1;
   int          last_out = -1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_y(input logic signed [15:0] x);
      longint u, idx, f, d, r;
      if (x < -16384) return tbl[0];
      if (x >= 16384) return tbl[64];
      u   = longint'(x) + 16384;
      idx = u >> 9;
      f   = u & 511;
      d   = longint'(tbl[idx+1]) - longint'(tbl[idx]);
      r   = longint'(tbl[idx]) + ((d * f + 256) >>> 9);
      return r[15:0];
   endfunction

   function automatic string tag_of(input logic signed [15:0] x);
      longint f;
      if (x < -16384) return "R5";
      if (x >= 16384) return "R6";
      f = (longint'(x) + 16384) & 511;
      if (f == 0) return "R7";
      if (f == 256) return "R8";
      return "R4";
   endfunction

   // Called at a falling edge: drives one cycle and checks outputs after it.
   task automatic run_cycle(input logic v, input logic signed [15:0] x, output logic acc);
      in_valid = v;
      in_x     = x;
      #0.1;
      check(in_ready == !last_acc, "R2", in_ready, !last_acc);
      acc = v && in_ready;
      @(posedge clk);
      @(negedge clk);
      cyc++;
      for (int k = 4; k >= 2; k--) begin
         pv[k] = pv[k-1]; py[k] = py[k-1]; pt[k] = pt[k-1];
      end
      pv[1] = acc; py[1] = ref_y(x); pt[1] = tag_of(x);
      last_acc = acc;
      check(out_valid == pv[4], "R3", out_valid, pv[4]);
      if (out_valid && pv[4]) begin
         check(out_y == py[4], pt[4], out_y, py[4]);
         if (first_out < 0) first_out = cyc;
         last_out = cyc;
      end
   endtask

   task automatic drain();
      logic a;
      for (int k = 0; k < 6; k++) run_cycle(1'b0, '0, a);
   endtask

   task automatic write_entry(input int a, input logic [15:0] d);
      tbl_we = 1'b1; tbl_addr = 7'(a); tbl_wdata = d;
      @(posedge clk);
      @(negedge clk);
      tbl_we = 1'b0;
      tbl[a] = d;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic a;
      int   n;
      int   idle_next;
      for (int k = 1; k <= 4; k++) begin pv[k] = 1'b0; py[k] = '0; pt[k] = ""; end

      // stimulus list: edges, saturation, ties, boundaries, sweep
      stim[n_stim++] = -16'sd32768; stim[n_stim++] = -16'sd16385;
      stim[n_stim++] = -16'sd16384; stim[n_stim++] = -16'sd16383;
      stim[n_stim++] = -16'sd1;     stim[n_stim++] = 16'sd0;
      stim[n_stim++] = 16'sd1;      stim[n_stim++] = 16'sd255;
      stim[n_stim++] = 16'sd256;    stim[n_stim++] = 16'sd257;
      stim[n_stim++] = 16'sd16383;  stim[n_stim++] = 16'sd16384;
      stim[n_stim++] = 16'sd32767;  stim[n_stim++] = -16'sd16128;
      for (int k = 0; k < 64; k++) stim[n_stim++] = 16'(-16384 + 512 * k);
      for (int k = 0; k < 64; k++) stim[n_stim++] = 16'(-16384 + 512 * k + 256);
      for (int j = 0; j < 700; j++) stim[n_stim++] = 16'(-32768 + 93 * j);

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(in_ready == 1'b1, "R1", in_ready, 1);
      check(out_valid == 1'b0, "R1", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", in_ready, 1);
      check(out_valid == 1'b0, "R1", out_valid, 0);

      // R9: preload the curve through the write port
      for (int k = 0; k <= 64; k++)
         write_entry(k, 16'((k * k * 97 + k * 1013 + 5) & 16'hFFFF));

      // streamed sweep with an idle slot inserted now and then
      n = 0;
      idle_next = 0;
      while (n < n_stim) begin
         if (idle_next != 0) begin
            run_cycle(1'b0, stim[n], a);
            idle_next = 0;
         end else begin
            run_cycle(1'b1, stim[n], a);
            if (a) begin
               if ((n % 7) == 6) idle_next = 1;
               n++;
            end
         end
      end
      drain();

      // R10: 20 inputs back to back, results every second cycle
      first_out = -1; last_out = -1;
      n = 0;
      while (n < 20) begin
         run_cycle(1'b1, 16'(-16000 + 1531 * n), a);
         if (a) n++;
      end
      drain();
      check(last_out - first_out == 38, "R10", last_out - first_out, 38);

      // R9: rewrite an end entry, then saturate onto it
      write_entry(0, 16'h1234);
      write_entry(64, 16'hBEEF);
      last_acc = 1'b0;
      n = 0;
      while (n < 2) begin
         run_cycle(1'b1, (n == 0) ? -16'sd30000 : 16'sd30000, a);
         if (a) n++;
      end
      drain();
      check(tbl[0] == 16'h1234, "R9", tbl[0], 16'h1234);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule